// File: doc/BRIEF.md
# Byte-Granular Shift and Rotate Unit

This unit moves whole 6-bit bytes inside a sign-magnitude accumulator, or inside the ten-byte pair formed by the accumulator and its extension register. Each register word carries one sign bit and five 6-bit bytes. A shift or rotate touches only the byte fields. Both sign bits always keep their values.

The caller supplies both register words, a byte count and a 3-bit operation code. The count is an already computed effective address. One clock edge later, the unit presents the two updated words. There are six operations:
- left or right shift of the accumulator alone;
- left or right shift of the concatenated pair, with the accumulator as the more significant half;
- left or right circular rotation of the pair.

Non-circular shifts discard the bytes that leave the field and fill the vacated positions with zero.

Top module: `byte_shift_unit`

## Requirements
- R1: A word is 31 bits: bit 30 is the sign, and bytes 1 to 5 sit at bits [29:24], [23:18], [17:12], [11:6] and [5:0], with byte 1 the most significant. On every clock edge outside reset, the outputs take the result computed from that edge's inputs. While rst_n is low, both outputs are zero.
- R2: Opcode 0 shifts the accumulator bytes left by the count, fills zero bytes on the right, and leaves the extension unchanged.
- R3: Opcode 1 shifts the accumulator bytes right by the count, fills zero bytes on the left, and leaves the extension unchanged.
- R4: Opcode 2 shifts the ten-byte pair left by the count, with accumulator byte 1 as the most significant byte of the pair and extension byte 5 as the least. Zero bytes fill from the right.
- R5: Opcode 3 shifts the ten-byte pair right by the count. Zero bytes fill from the left.
- R6: Opcode 4 rotates the pair left by the count modulo 10. A byte leaving the top re-enters at the bottom.
- R7: Opcode 5 rotates the pair right by the count modulo 10.
- R8: A count of 5 or more clears every accumulator byte for opcodes 0 and 1. A count of 10 or more clears every byte of both registers for opcodes 2 and 3.
- R9: A count of zero returns both words unchanged for every opcode.
- R10: Neither sign bit is changed by any operation.
- R11: Opcodes 6 and 7 pass both words through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_in | input | 31 | Accumulator word before the operation |
| ext_in | input | 31 | Extension word before the operation |
| cnt_in | input | 12 | Byte count (effective address) |
| op_in | input | 3 | Operation code |
| acc_out | output | 31 | Registered accumulator result |
| ext_out | output | 31 | Registered extension result |

## Verification
The bench steps every opcode through the counts around each boundary: 0, 1, 4, 5, 9, 10, 11 and 19, plus the largest count.

Each boundary catches a specific fault:
- A unit that clamps at the wrong count leaves stray bytes where zeros belong, or clears a field that should still hold data.
- A rotation that does not reduce its count modulo 10 loses bytes instead of wrapping them.

Random signs on both words expose any shift that drags a sign bit into the byte field, or bytes into a sign. Single-register shifts are checked for any change to the extension, which catches a unit that leaks the pair path into those opcodes.

// File: rtl/byte_shift_unit.sv
module byte_shift_unit #(
  parameter int BYTE_W = 6,
  parameter int NB     = 5,
  parameter int CNT_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NB*BYTE_W:0]      acc_in,
  input  logic [NB*BYTE_W:0]      ext_in,
  input  logic [CNT_W-1:0]        cnt_in,
  input  logic [2:0]              op_in,
  output logic [NB*BYTE_W:0]      acc_out,
  output logic [NB*BYTE_W:0]      ext_out
);
  localparam int MW = NB * BYTE_W;
  localparam int PB = 2 * NB;
  localparam int PW = 2 * MW;
  localparam int SW = CNT_W + $clog2(BYTE_W + 1) + 1;

  logic [MW-1:0]   am, xm, na, nx;
  logic [PW-1:0]   pr, pl, prr;
  logic [2*PW-1:0] dbl, rl_w, rr_w;
  logic [SW-1:0]   cnt_x, sh, rot_l, rot_r;

  assign am    = acc_in[MW-1:0];
  assign xm    = ext_in[MW-1:0];
  assign pr    = {am, xm};
  assign cnt_x = SW'(cnt_in);
  assign sh    = cnt_x * SW'(BYTE_W);
  assign rot_l = (cnt_x % SW'(PB)) * SW'(BYTE_W);
  assign rot_r = ((SW'(PB) - (cnt_x % SW'(PB))) % SW'(PB)) * SW'(BYTE_W);

  assign dbl  = {pr, pr};
  assign rl_w = dbl << rot_l;
  assign rr_w = dbl << rot_r;
  assign pl   = (cnt_x >= SW'(PB)) ? '0 : pr << sh;
  assign prr  = (cnt_x >= SW'(PB)) ? '0 : pr >> sh;

  always_comb begin
    na = am;
    nx = xm;
    case (op_in)
      3'd0: na = (cnt_x >= SW'(NB)) ? '0 : am << sh;
      3'd1: na = (cnt_x >= SW'(NB)) ? '0 : am >> sh;
      3'd2: {na, nx} = pl;
      3'd3: {na, nx} = prr;
      3'd4: {na, nx} = rl_w[2*PW-1:PW];
      3'd5: {na, nx} = rr_w[2*PW-1:PW];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out <= '0;
      ext_out <= '0;
    end else begin
      acc_out <= {acc_in[MW], na};
      ext_out <= {ext_in[MW], nx};
    end
  end
endmodule

// File: rtl/byte_shift_unit_chk.sv
module byte_shift_unit_chk #(
  parameter int BYTE_W = 6,
  parameter int NB     = 5,
  parameter int CNT_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NB*BYTE_W:0] acc_in,
  input logic [NB*BYTE_W:0] ext_in,
  input logic [CNT_W-1:0]   cnt_in,
  input logic [2:0]         op_in,
  input logic [NB*BYTE_W:0] acc_out,
  input logic [NB*BYTE_W:0] ext_out
);
  localparam int MW = NB * BYTE_W;

  // R10
  acc_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> acc_out[MW] == $past(acc_in[MW]));

  // R10
  ext_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ext_out[MW] == $past(ext_in[MW]));

  // R9
  zero_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_in == '0) |=> (acc_out == $past(acc_in) && ext_out == $past(ext_in)));

  // R2
  single_ext_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in <= 3'd1) |=> ext_out == $past(ext_in));

  // R8
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in <= 3'd1 && cnt_in >= CNT_W'(NB)) |=> acc_out[MW-1:0] == '0);

  // R6
  rotate_keep_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in == 3'd4 || op_in == 3'd5) |=>
      $countones({acc_out[MW-1:0], ext_out[MW-1:0]}) ==
      $countones($past({acc_in[MW-1:0], ext_in[MW-1:0]})));

  // R11
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in >= 3'd6) |=> (acc_out == $past(acc_in) && ext_out == $past(ext_in)));
endmodule

bind byte_shift_unit byte_shift_unit_chk #(.BYTE_W(BYTE_W), .NB(NB), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .ext_in(ext_in),
  .cnt_in(cnt_in), .op_in(op_in), .acc_out(acc_out), .ext_out(ext_out));

// File: tb/byte_shift_unit_test.sv
`timescale 1ns/1ps
module byte_shift_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] acc_in = '0, ext_in = '0;
  logic [11:0] cnt_in = '0;
  logic [2:0]  op_in = '0;
  logic [30:0] acc_out, ext_out;

  int checks = 0, errors = 0;
  bit done = 0;

  byte_shift_unit uut (.clk(clk), .rst_n(rst_n), .acc_in(acc_in), .ext_in(ext_in),
    .cnt_in(cnt_in), .op_in(op_in), .acc_out(acc_out), .ext_out(ext_out));

  always #2.5 clk = ~clk;

  function automatic logic [61:0] model(int op, int n, logic [30:0] a, logic [30:0] x);
    int b[10];
    int r[10];
    logic [30:0] ra, rx;
    for (int i = 0; i < 5; i++) begin
      b[i]   = int'(a[29-6*i -: 6]);
      b[i+5] = int'(x[29-6*i -: 6]);
    end
    for (int i = 0; i < 10; i++) r[i] = b[i];
    case (op)
      0: for (int i = 0; i < 5; i++) r[i] = (i + n < 5) ? b[i+n] : 0;
      1: for (int i = 0; i < 5; i++) r[i] = (i - n >= 0) ? b[i-n] : 0;
      2: for (int i = 0; i < 10; i++) r[i] = (i + n < 10) ? b[i+n] : 0;
      3: for (int i = 0; i < 10; i++) r[i] = (i - n >= 0) ? b[i-n] : 0;
      4: for (int i = 0; i < 10; i++) r[i] = b[(i + n) % 10];
      5: for (int i = 0; i < 10; i++) r[i] = b[(i - (n % 10) + 10) % 10];
      default: ;
    endcase
    ra = '0; rx = '0;
    ra[30] = a[30]; rx[30] = x[30];
    for (int i = 0; i < 5; i++) begin
      ra[29-6*i -: 6] = r[i][5:0];
      rx[29-6*i -: 6] = r[i+5][5:0];
    end
    return {ra, rx};
  endfunction

  function automatic string tag_of(int op, int n);
    if (n == 0) return "R9";
    if (op >= 6) return "R11";
    if (op <= 1 && n >= 5) return "R8";
    if ((op == 2 || op == 3) && n >= 10) return "R8";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  logic [61:0] exp_v;
  string       exp_tag;
  bit          have_exp = 0;

  task automatic compare();
    checks++;
    if ({acc_out, ext_out} !== exp_v) begin
      errors++;
      $display("FAIL %s: acc=%h ext=%h expected acc=%h ext=%h",
               exp_tag, acc_out, ext_out, exp_v[61:31], exp_v[30:0]);
    end
    checks++;
    if (acc_out[30] !== exp_v[61] || ext_out[30] !== exp_v[30]) begin
      errors++;
      $display("FAIL R10: signs %b%b expected %b%b", acc_out[30], ext_out[30], exp_v[61], exp_v[30]);
    end
  endtask

  task automatic step(int op, int n, logic [30:0] a, logic [30:0] x);
    @(negedge clk);
    if (have_exp) compare();
    op_in = 3'(op); cnt_in = 12'(n); acc_in = a; ext_in = x;
    exp_v = model(op, n, a, x);
    exp_tag = tag_of(op, n);
    have_exp = 1;
  endtask

  int cnts[10] = '{0, 1, 2, 4, 5, 9, 10, 11, 19, 4095};

  initial begin
    acc_in = 31'h5555_5555; ext_in = 31'h2AAA_AAAA;
    repeat (3) @(negedge clk);
    checks++;
    if (acc_out !== '0 || ext_out !== '0) begin
      errors++;
      $display("FAIL R1: reset acc=%h ext=%h expected 0 0", acc_out, ext_out);
    end
    rst_n = 1'b1;
    // R1 byte layout: distinct bytes so ordering errors show up
    step(0, 1, {1'b1, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5}, {1'b0, 6'd6, 6'd7, 6'd8, 6'd9, 6'd10});
    step(5, 3, {1'b0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5}, {1'b1, 6'd6, 6'd7, 6'd8, 6'd9, 6'd10});
    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 10; k++)
        for (int s = 0; s < 4; s++)
          step(op, cnts[k], {s[0], 30'($urandom)}, {s[1], 30'($urandom)});
    for (int t = 0; t < 400; t++)
      step(int'($urandom_range(0, 7)),
           ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 4095)) : int'($urandom_range(0, 12)),
           31'($urandom), 31'($urandom));
    @(negedge clk);
    compare();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule